// File: doc/BRIEF.md
# Drive status word generator

This block holds the error and seek state of a small set of disk drives behind one controller and builds the 16-bit word that a status-check command returns. The transfer and seek logic report events through per-drive pulse inputs: end-of-cylinder, address mismatch, write to a protected drive, data error, seek start and seek done. Each error event sets a sticky bit for that drive. The seeking bit follows the seek start and seek done pulses.

A status read is a one-cycle strobe with a drive index. On the next clock edge the block registers the word for that drive on `status_o`. If the drive's heads are unloaded, the word reports not-ready and none of the stored bits. The block also computes a summary error bit and sets an identity bit for odd-numbered drives. In the same edge it clears the error bits of the drive that was read. The seeking bit is not cleared by a read. Between reads, `status_o` keeps its last value.

Top module: `drive_status_word`

## Requirements
- R1: The word layout is: bit 7 identity, bit 6 not ready, bit 5 end of cylinder, bit 4 address error, bit 3 flagged, bit 2 seeking, bit 1 data error, bit 0 summary error. Bits 15..8 are always zero.
- R2: A pulse on one of a drive's error inputs sets the matching sticky bit of that drive only. A write attempt on a protected drive sets the flagged bit.
- R3: The summary bit is the OR of not ready, end of cylinder, address error, flagged and data error. The seeking bit does not contribute to it.
- R4: When the selected drive's heads are unloaded, the word carries only not ready, the summary bit (set) and the identity bit.
- R5: The identity bit is set when the selected drive index is odd (drive 1 of two) and clear when it is even (drive 0).
- R6: A read clears end of cylinder, address error, flagged and data error of the selected drive. It keeps the seeking bit and leaves every other drive untouched. This holds even when the heads are unloaded.
- R7: Seek start sets the seeking bit and seek done clears it. When both arrive in the same cycle, start wins.
- R8: When an error set and a read of the same drive fall in the same cycle, the returned word shows the state from before that cycle, and the set bit stays stored after the read.
- R9: `status_o` is loaded on the clock edge that samples the read strobe. It holds its value in every cycle without a strobe.
- R10: Synchronous active-low reset clears the state of all drives and clears `status_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eoc_set_i | input | NUM_DRIVES | End-of-cylinder event, one bit per drive |
| addr_err_set_i | input | NUM_DRIVES | Address mismatch event, one bit per drive |
| prot_viol_i | input | NUM_DRIVES | Write attempted on protected drive, one bit per drive |
| data_err_set_i | input | NUM_DRIVES | Data error event, one bit per drive |
| seek_start_i | input | NUM_DRIVES | Seek begins, one bit per drive |
| seek_done_i | input | NUM_DRIVES | Seek ends, one bit per drive |
| heads_loaded_i | input | NUM_DRIVES | Heads loaded level, one bit per drive |
| rd_stb_i | input | 1 | Status read strobe |
| rd_drv_i | input | DRV_W | Drive index for the read |
| status_o | output | 16 | Registered status word |

## Verification
Two functions can land in the same cycle: a read that clears a drive's errors and a new error event for that drive. The same applies to seek start and seek done. The bench provokes both collisions with directed steps, and the random phase drives event pulses in almost every cycle. A reference model applies the "set wins" rule. The bench then checks that the word returned in the collision cycle shows the state from before the cycle, and that the next read shows the newly set bit.

// File: rtl/dsw_pkg.sv
// Package: bit positions of the status word and the per-drive stored state.
// Assumes a 16-bit word with the upper byte always zero.
package dsw_pkg;
    localparam int WORD_W   = 16;
    localparam int POS_ID   = 7;
    localparam int POS_NRDY = 6;
    localparam int POS_EOC  = 5;
    localparam int POS_AER  = 4;
    localparam int POS_FLG  = 3;
    localparam int POS_SEEK = 2;
    localparam int POS_DTE  = 1;
    localparam int POS_ANY  = 0;

    typedef struct packed {
        logic eoc;
        logic aer;
        logic flg;
        logic seek;
        logic dte;
    } drv_state_t;
endpackage

// File: rtl/dsw_drive_reg.sv
// Per-drive sticky state. Error bits set on event pulses and clear on a
// read of this drive, with set winning. The seeking bit follows start/done,
// with start winning. Assumes one-cycle pulses from the transfer logic.
module dsw_drive_reg
    import dsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eoc_set,
    input  logic       aer_set,
    input  logic       flg_set,
    input  logic       dte_set,
    input  logic       seek_start,
    input  logic       seek_done,
    input  logic       rd_clr,
    output drv_state_t state
);
    // Update sticky error bits and seek state on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
        end else begin
            state.eoc  <= eoc_set | (state.eoc & ~rd_clr);
            state.aer  <= aer_set | (state.aer & ~rd_clr);
            state.flg  <= flg_set | (state.flg & ~rd_clr);
            state.dte  <= dte_set | (state.dte & ~rd_clr);
            state.seek <= seek_start | (state.seek & ~seek_done);
        end
    end
endmodule

// File: rtl/dsw_format.sv
// Builds the status word from one drive's stored state. Applies the
// not-ready override, the summary error bit and the identity bit.
// Purely combinational.
module dsw_format
    import dsw_pkg::*;
(
    input  drv_state_t        state,
    input  logic              loaded,
    input  logic              id_odd,
    output logic [WORD_W-1:0] word
);
    logic nrdy;
    logic [WORD_W-1:0] body;

    // Place the stored bits, or the not-ready flag alone when unloaded.
    always_comb begin
        nrdy = ~loaded;
        body = '0;
        if (loaded) begin
            body[POS_EOC]  = state.eoc;
            body[POS_AER]  = state.aer;
            body[POS_FLG]  = state.flg;
            body[POS_SEEK] = state.seek;
            body[POS_DTE]  = state.dte;
        end
        body[POS_NRDY] = nrdy;
    end

    // Add the summary error bit (seeking excluded) and the identity bit.
    always_comb begin
        word          = body;
        word[POS_ANY] = body[POS_NRDY] | body[POS_EOC] | body[POS_AER]
                      | body[POS_FLG]  | body[POS_DTE];
        word[POS_ID]  = id_odd;
    end
endmodule

// File: rtl/drive_status_word.sv
// Top: one sticky register set per drive, a read-select mux, the word
// formatter and the output register. Assumes rd_drv_i < NUM_DRIVES whenever
// rd_stb_i is high.
module drive_status_word
    import dsw_pkg::*;
#(
    parameter  int NUM_DRIVES = 2,
    localparam int DRV_W      = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_DRIVES-1:0] eoc_set_i,
    input  logic [NUM_DRIVES-1:0] addr_err_set_i,
    input  logic [NUM_DRIVES-1:0] prot_viol_i,
    input  logic [NUM_DRIVES-1:0] data_err_set_i,
    input  logic [NUM_DRIVES-1:0] seek_start_i,
    input  logic [NUM_DRIVES-1:0] seek_done_i,
    input  logic [NUM_DRIVES-1:0] heads_loaded_i,
    input  logic                  rd_stb_i,
    input  logic [DRV_W-1:0]      rd_drv_i,
    output logic [WORD_W-1:0]     status_o
);
    drv_state_t        drv_state [NUM_DRIVES];
    logic [NUM_DRIVES-1:0] rd_clr;
    drv_state_t        sel_state;
    logic              sel_loaded;
    logic [WORD_W-1:0] sel_word;

    genvar gd;
    generate
        for (gd = 0; gd < NUM_DRIVES; gd++) begin : g_drv
            // Decode the read strobe into this drive's clear request.
            assign rd_clr[gd] = rd_stb_i && (rd_drv_i == DRV_W'(gd));

            dsw_drive_reg u_reg (
                .clk        (clk),
                .rst_n      (rst_n),
                .eoc_set    (eoc_set_i[gd]),
                .aer_set    (addr_err_set_i[gd]),
                .flg_set    (prot_viol_i[gd]),
                .dte_set    (data_err_set_i[gd]),
                .seek_start (seek_start_i[gd]),
                .seek_done  (seek_done_i[gd]),
                .rd_clr     (rd_clr[gd]),
                .state      (drv_state[gd])
            );
        end
    endgenerate

    // Select the state and head-load level of the addressed drive.
    always_comb begin
        sel_state  = '0;
        sel_loaded = 1'b0;
        for (int d = 0; d < NUM_DRIVES; d++) begin
            if (rd_drv_i == DRV_W'(d)) begin
                sel_state  = drv_state[d];
                sel_loaded = heads_loaded_i[d];
            end
        end
    end

    dsw_format u_fmt (
        .state  (sel_state),
        .loaded (sel_loaded),
        .id_odd (rd_drv_i[0]),
        .word   (sel_word)
    );

    // Capture the word on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
        end else if (rd_stb_i) begin
            status_o <= sel_word;
        end
    end
endmodule

// File: rtl/dsw_checker.sv
// Checker for drive_status_word. Observes ports only; bound below.
module dsw_checker #(
    parameter  int NUM_DRIVES = 2,
    localparam int DRV_W      = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_DRIVES-1:0] heads_loaded_i,
    input logic                  rd_stb_i,
    input logic [DRV_W-1:0]      rd_drv_i,
    input logic [15:0]           status_o
);
    // R1: upper byte never carries anything.
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_i |=> (status_o[15:8] == 8'h00));

    // R3: summary bit follows the error subset, seeking excluded.
    a_r3_summary: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_i |=> (status_o[0] == (status_o[6] | status_o[5] | status_o[4]
                                      | status_o[3] | status_o[1])));

    // R4: unloaded heads give only not-ready, summary and identity.
    a_r4_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && !heads_loaded_i[rd_drv_i])
        |=> (status_o[6] && status_o[0] && (status_o[5:1] == 5'd0)));

    // R4: loaded heads never report not-ready.
    a_r4_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && heads_loaded_i[rd_drv_i]) |=> !status_o[6]);

    // R5: identity bit follows the parity of the selected drive index.
    a_r5_identity: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_i |=> (status_o[7] == $past(rd_drv_i[0])));

    // R9: output holds without a strobe.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> $stable(status_o));
endmodule

bind drive_status_word dsw_checker #(.NUM_DRIVES(NUM_DRIVES)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .heads_loaded_i (heads_loaded_i),
    .rd_stb_i       (rd_stb_i),
    .rd_drv_i       (rd_drv_i),
    .status_o       (status_o)
);

// File: tb/drive_status_word_tb_top.sv
module drive_status_word_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  eoc_set_i = '0, addr_err_set_i = '0, prot_viol_i = '0;
    logic [1:0]  data_err_set_i = '0, seek_start_i = '0, seek_done_i = '0;
    logic [1:0]  heads_loaded_i = 2'b11;
    logic        rd_stb_i = 1'b0;
    logic [0:0]  rd_drv_i = '0;
    logic [15:0] status_o;

    int n_chk = 0;
    int n_err = 0;

    logic [1:0]  m_eoc = '0, m_aer = '0, m_flg = '0, m_seek = '0, m_dte = '0;
    logic [15:0] m_out = '0;

    always #2 clk = ~clk;

    drive_status_word #(.NUM_DRIVES(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .eoc_set_i(eoc_set_i), .addr_err_set_i(addr_err_set_i),
        .prot_viol_i(prot_viol_i), .data_err_set_i(data_err_set_i),
        .seek_start_i(seek_start_i), .seek_done_i(seek_done_i),
        .heads_loaded_i(heads_loaded_i), .rd_stb_i(rd_stb_i),
        .rd_drv_i(rd_drv_i), .status_o(status_o)
    );

    function automatic logic [15:0] exp_word(input int d, input logic ld);
        logic [15:0] w;
        w = '0;
        w[7] = d[0];
        if (!ld) begin
            w[6] = 1'b1;
        end else begin
            w[5] = m_eoc[d]; w[4] = m_aer[d]; w[3] = m_flg[d];
            w[2] = m_seek[d]; w[1] = m_dte[d];
        end
        w[0] = w[6] | w[5] | w[4] | w[3] | w[1];
        return w;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive inputs after a falling edge, update model, sample after the next falling edge.
    task automatic step(input logic [1:0] eoc, aer, prot, dte, ss, sd, ld,
                        input logic rd, input int drv, input string tag);
        eoc_set_i = eoc; addr_err_set_i = aer; prot_viol_i = prot;
        data_err_set_i = dte; seek_start_i = ss; seek_done_i = sd;
        heads_loaded_i = ld; rd_stb_i = rd; rd_drv_i = drv[0:0];
        if (rd) m_out = exp_word(drv, ld[drv]);
        for (int d = 0; d < 2; d++) begin
            logic clr;
            clr = rd && (drv == d);
            m_eoc[d]  = eoc[d]  | (m_eoc[d] & ~clr);
            m_aer[d]  = aer[d]  | (m_aer[d] & ~clr);
            m_flg[d]  = prot[d] | (m_flg[d] & ~clr);
            m_dte[d]  = dte[d]  | (m_dte[d] & ~clr);
            m_seek[d] = ss[d]   | (m_seek[d] & ~sd[d]);
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, status_o, m_out);
    endtask

    task automatic rd(input int drv, input logic [1:0] ld, input string tag);
        step(0, 0, 0, 0, 0, 0, ld, 1'b1, drv, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rd_stb_i = 1'b0;
        {eoc_set_i, addr_err_set_i, prot_viol_i, data_err_set_i, seek_start_i, seek_done_i} = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_eoc = '0; m_aer = '0; m_flg = '0; m_seek = '0; m_dte = '0; m_out = '0;
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h0000_5EED));
        do_reset();
        check("R10 reset output", status_o, 16'h0000);
        rd(0, 2'b11, "R5 drive0 clean");
        check("R5 drive0 word", status_o, 16'h0000);
        rd(1, 2'b11, "R5 drive1 identity");
        check("R5 drive1 word", status_o, 16'h0080);
        step(2'b01, 0, 0, 0, 0, 0, 2'b11, 0, 0, "R9 hold during set");
        rd(0, 2'b11, "R2 R1 R3 eoc drive0");
        check("R1 eoc layout", status_o, 16'h0021);
        rd(0, 2'b11, "R6 cleared after read");
        step(0, 2'b10, 0, 0, 0, 0, 2'b11, 0, 0, "R9 idle");
        rd(0, 2'b11, "R2 other drive untouched");
        rd(1, 2'b11, "R2 address error drive1");
        check("R2 aer word", status_o, 16'h0091);
        step(0, 0, 2'b01, 0, 0, 0, 2'b11, 0, 0, "R9 idle");
        rd(0, 2'b11, "R2 protect sets flagged");
        check("R2 flagged word", status_o, 16'h0009);
        step(0, 0, 0, 0, 2'b01, 0, 2'b11, 0, 0, "R7 seek start");
        rd(0, 2'b11, "R3 seeking not in summary");
        check("R3 seek word", status_o, 16'h0004);
        rd(0, 2'b11, "R6 seeking kept");
        step(0, 0, 0, 0, 0, 2'b01, 2'b11, 0, 0, "R7 seek done");
        rd(0, 2'b11, "R7 seeking cleared");
        step(0, 0, 0, 0, 2'b01, 2'b01, 2'b11, 0, 0, "R7 start and done");
        rd(0, 2'b11, "R7 start wins");
        check("R7 word", status_o, 16'h0004);
        step(0, 0, 0, 0, 0, 2'b01, 2'b11, 0, 0, "R7 done");
        step(0, 0, 0, 2'b10, 0, 0, 2'b11, 0, 0, "R9 idle");
        rd(1, 2'b01, "R4 unloaded drive1");
        check("R4 word", status_o, 16'h00C1);
        rd(1, 2'b11, "R6 cleared under unload");
        check("R6 word", status_o, 16'h0080);
        step(0, 0, 0, 2'b01, 0, 0, 2'b11, 1'b1, 0, "R8 set during read");
        check("R8 old state", status_o, 16'h0000);
        rd(0, 2'b11, "R8 set survives");
        check("R8 word", status_o, 16'h0003);
        step(2'b11, 2'b11, 0, 0, 2'b11, 0, 2'b11, 0, 0, "R9 load state");
        do_reset();
        rd(0, 2'b11, "R10 drive0 cleared");
        rd(1, 2'b11, "R10 drive1 cleared");
        for (int i = 0; i < 400; i++) begin
            logic [1:0] ev [6];
            for (int k = 0; k < 6; k++)
                ev[k] = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
            step(ev[0], ev[1], ev[2], ev[3], ev[4], ev[5],
                 (($urandom % 5) == 0) ? 2'($urandom) : 2'b11,
                 logic'(($urandom % 2) == 0), int'($urandom % 2),
                 "R2 R3 R4 R6 R7 R8 R9 random");
        end
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule